// File: doc/BRIEF.md
# Width-Aware Card Data FIFO

This block buffers payload bytes between a processor register port and a byte-wide card data link. There are two 32-byte circular buffers, one for each direction. The processor writes into the transmit buffer and reads from the receive buffer with accesses of 1, 2 or 4 bytes. Each access is packed into bytes, or unpacked from them, most-significant lane first. The card side is two byte streams with valid/ready handshakes. One byte moves per clock cycle, in the direction chosen when the transfer starts.

A start pulse loads a remaining-byte counter with block length times block count and empties both buffers. While the counter is nonzero, the card-enable input is high and the buffer can supply or accept a byte, the stream moves one byte per cycle and the counter decrements. When the counter reaches zero, the transfer stops and completion flags are raised. A flush pulse discards transmit bytes that are still pending, so that new data goes out next. Back-pressure on the transmit stream holds the head byte on the data pins until the card takes it. On the receive stream, ready falls whenever the receive buffer is full.

Top module: `card_data_fifo`

## Requirements
- R1: After reset, busy, cd_tx_valid, cd_rx_ready, tx_req, rx_req, data_done and prog_done are all low.
- R2: A write with acc_size 0 (1 byte), 1 (2 bytes) or 2/3 (4 bytes) of w bytes queues the bytes in this order: first acc_wdata[8w-1:8w-8], then successively lower lanes. Lanes above bit 8w-1 are ignored. The bytes leave on cd_tx_data in queue order.
- R3: A write queues only as many bytes as the 32-byte transmit buffer has room for. Lanes beyond that are dropped.
- R4: A read of w bytes returns its first byte in acc_rdata[8w-1:8w-8] and the later bytes in lower lanes. The read data appears the cycle after acc_rd. Lanes for which the receive buffer had no byte read as zero, and so do all bits above 8w-1.
- R5: xfer_start loads the remaining count with blk_len*blk_cnt, empties both buffers and clears data_done, prog_done and rx_req. Exactly that many bytes then cross the card stream.
- R6: At most one byte moves per cycle. cd_tx_valid is high only while a write-direction transfer is busy, bytes remain and the transmit buffer is not empty. While the transmit stream is stalled, cd_tx_data holds its value.
- R7: cd_rx_ready is high only while a read-direction transfer is busy, bytes remain and the receive buffer holds fewer than 32 bytes.
- R8: The cycle after the remaining count is zero, busy falls and data_done sets. prog_done also sets, but only in the write direction. A transfer of zero length completes without moving any byte.
- R9: tx_req is high while a write-direction transfer is busy with bytes remaining.
- R10: rx_req sets on every byte received. It clears on a read access unless a byte arrives in the same cycle.
- R11: tx_flush empties the transmit buffer. Bytes written after it are the next ones sent.
- R12: While clk_en is low, cd_tx_valid and cd_rx_ready stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Card clock running; gates all card transfers |
| xfer_start | input | 1 | Pulse: load count, empty buffers, begin transfer |
| xfer_dir_wr | input | 1 | Direction sampled at start: 1 = to card, 0 = from card |
| blk_len | input | 12 | Bytes per block |
| blk_cnt | input | 16 | Number of blocks |
| acc_wr | input | 1 | Processor write to transmit buffer |
| acc_rd | input | 1 | Processor read from receive buffer |
| acc_size | input | 2 | Access width: 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, registered |
| tx_flush | input | 1 | Pulse: discard pending transmit bytes |
| cd_tx_valid | output | 1 | Transmit byte available |
| cd_tx_ready | input | 1 | Card accepts transmit byte |
| cd_tx_data | output | 8 | Transmit byte |
| cd_rx_valid | input | 1 | Card offers a receive byte |
| cd_rx_ready | output | 1 | Block accepts receive byte |
| cd_rx_data | input | 8 | Receive byte |
| busy | output | 1 | Transfer in progress |
| tx_req | output | 1 | Transmit service request |
| rx_req | output | 1 | Receive service request |
| data_done | output | 1 | Transfer finished (sticky until next start) |
| prog_done | output | 1 | Write-direction transfer finished (sticky) |

## Verification
The assertions assume that xfer_start is not raised at the same time as a flush or a processor access. They also assume that the card side does not depend on cd_tx_valid staying high across a cycle in which clk_en drops. The stimulus respects this by driving each control pulse alone, one cycle wide, on the falling edge. It changes clk_en only while the transmit buffer is empty or no handshake is pending. The card source and sink in the bench assert valid and ready on their own and count only completed handshakes.

// File: rtl/cdf_pkg.sv
package cdf_pkg;
  localparam int LANES = 4;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WALT = 2'd3
  } acc_size_e;

  function automatic logic [2:0] size_bytes(input acc_size_e s);
    case (s)
      SZ_BYTE: return 3'd1;
      SZ_HALF: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/cdf_ring.sv
module cdf_ring #(
  parameter int DEPTH  = 32,
  parameter int PUSH_N = 4,
  parameter int POP_N  = 1,
  localparam int PW  = $clog2(DEPTH),
  localparam int UW  = $clog2(PUSH_N + 1),
  localparam int OW  = $clog2(POP_N + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear,
  input  logic                   flush,
  input  logic [UW-1:0]          push_n,
  input  logic [PUSH_N-1:0][7:0] push_bytes,
  input  logic [OW-1:0]          pop_n,
  output logic [POP_N-1:0][7:0]  peek,
  output logic [PW:0]            count
);
  logic [PW:0]   head;
  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wr_idx [PUSH_N];

  always_comb begin
    for (int k = 0; k < PUSH_N; k++)
      wr_idx[k] = PW'(head[PW-1:0] + count[PW-1:0] + PW'(k));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      count <= '0;
    end else if (clear) begin
      count <= '0;
    end else if (flush) begin
      head[PW] <= ~head[PW];
      count    <= '0;
    end else begin
      head  <= head + (PW+1)'(pop_n);
      count <= count + (PW+1)'(push_n) - (PW+1)'(pop_n);
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < PUSH_N; k++)
      if (!clear && !flush && UW'(k) < push_n)
        mem[wr_idx[k]] <= push_bytes[k];
  end

  for (genvar k = 0; k < POP_N; k++) begin : g_peek
    assign peek[k] = mem[PW'(head[PW-1:0] + PW'(k))];
  end
endmodule

// File: rtl/cdf_lanes.sv
module cdf_lanes
  import cdf_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int PW = $clog2(DEPTH),
  localparam int NW = $clog2(LANES + 1),
  localparam int DW = 8 * LANES
) (
  input  logic                  acc_wr,
  input  logic                  acc_rd,
  input  acc_size_e             size,
  input  logic [DW-1:0]         wdata,
  input  logic [PW:0]           tx_count,
  input  logic [PW:0]           rx_count,
  input  logic [LANES-1:0][7:0] rx_peek,
  output logic [NW-1:0]         tx_push_n,
  output logic [LANES-1:0][7:0] tx_bytes,
  output logic [NW-1:0]         rx_pop_n,
  output logic [DW-1:0]         rdata_next
);
  logic [NW-1:0] w;
  logic [PW:0]   tx_free;
  logic [5:0]    shamt;
  logic [DW-1:0] aligned;
  logic [DW-1:0] gathered;

  always_comb begin
    w       = NW'(size_bytes(size));
    shamt   = {3'(3'd4 - 3'(w)), 3'b000};
    tx_free = (PW+1)'(DEPTH) - tx_count;
    if (!acc_wr)                          tx_push_n = '0;
    else if ((PW+1)'(w) <= tx_free)        tx_push_n = w;
    else                                  tx_push_n = NW'(tx_free);
    if (!acc_rd)                          rx_pop_n = '0;
    else if ((PW+1)'(w) <= rx_count)       rx_pop_n = w;
    else                                  rx_pop_n = NW'(rx_count);
    aligned = wdata << shamt;
    for (int k = 0; k < LANES; k++)
      gathered[8*(LANES-k)-1 -: 8] = (NW'(k) < rx_pop_n) ? rx_peek[k] : 8'h00;
    rdata_next = gathered >> shamt;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign tx_bytes[k] = aligned[8*(LANES-k)-1 -: 8];
  end
endmodule

// File: rtl/cdf_xfer.sv
module cdf_xfer #(
  parameter int DEPTH = 32,
  parameter int LEN_W = 12,
  parameter int CNT_W = 16,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = LEN_W + CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             dir_wr_in,
  input  logic [LEN_W-1:0] blk_len,
  input  logic [CNT_W-1:0] blk_cnt,
  input  logic             clk_en,
  input  logic [PW:0]      tx_count,
  input  logic [PW:0]      rx_count,
  input  logic             cd_tx_ready,
  input  logic             cd_rx_valid,
  input  logic             acc_rd,
  output logic             busy,
  output logic             cd_tx_valid,
  output logic             cd_rx_ready,
  output logic             tx_fire,
  output logic             rx_fire,
  output logic             tx_req,
  output logic             rx_req,
  output logic             data_done,
  output logic             prog_done,
  output logic [CW-1:0]    rem
);
  logic dir_wr;
  logic go;

  assign go          = busy && clk_en && (rem != '0);
  assign cd_tx_valid = go && dir_wr && (tx_count != '0);
  assign cd_rx_ready = go && !dir_wr && (rx_count != (PW+1)'(DEPTH));
  assign tx_fire     = cd_tx_valid && cd_tx_ready;
  assign rx_fire     = cd_rx_ready && cd_rx_valid;
  assign tx_req      = busy && dir_wr && (rem != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      dir_wr    <= 1'b0;
      rem       <= '0;
      data_done <= 1'b0;
      prog_done <= 1'b0;
      rx_req    <= 1'b0;
    end else if (start) begin
      busy      <= 1'b1;
      dir_wr    <= dir_wr_in;
      rem       <= CW'(blk_len) * CW'(blk_cnt);
      data_done <= 1'b0;
      prog_done <= 1'b0;
      rx_req    <= 1'b0;
    end else begin
      if (busy) begin
        if (rem == '0) begin
          busy      <= 1'b0;
          data_done <= 1'b1;
          prog_done <= dir_wr;
        end else if (tx_fire || rx_fire) begin
          rem <= rem - CW'(1);
        end
      end
      if (rx_fire)     rx_req <= 1'b1;
      else if (acc_rd) rx_req <= 1'b0;
    end
  end
endmodule

// File: rtl/card_data_fifo.sv
module card_data_fifo
  import cdf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int LEN_W = 12,
  parameter int CNT_W = 16,
  localparam int PW = $clog2(DEPTH),
  localparam int NW = $clog2(LANES + 1),
  localparam int DW = 8 * LANES,
  localparam int CW = LEN_W + CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic             xfer_start,
  input  logic             xfer_dir_wr,
  input  logic [LEN_W-1:0] blk_len,
  input  logic [CNT_W-1:0] blk_cnt,
  input  logic             acc_wr,
  input  logic             acc_rd,
  input  logic [1:0]       acc_size,
  input  logic [DW-1:0]    acc_wdata,
  output logic [DW-1:0]    acc_rdata,
  input  logic             tx_flush,
  output logic             cd_tx_valid,
  input  logic             cd_tx_ready,
  output logic [7:0]       cd_tx_data,
  input  logic             cd_rx_valid,
  output logic             cd_rx_ready,
  input  logic [7:0]       cd_rx_data,
  output logic             busy,
  output logic             tx_req,
  output logic             rx_req,
  output logic             data_done,
  output logic             prog_done
);
  logic [PW:0]           tx_count, rx_count;
  logic [NW-1:0]         tx_push_n, rx_pop_n;
  logic [LANES-1:0][7:0] tx_bytes, rx_peek;
  logic [0:0][7:0]       tx_peek, rx_push_bytes;
  logic [DW-1:0]         rdata_next;
  logic                  tx_fire, rx_fire;
  logic [CW-1:0]         rem;

  assign cd_tx_data       = tx_peek[0];
  assign rx_push_bytes[0] = cd_rx_data;

  cdf_lanes #(.DEPTH(DEPTH)) u_lanes (
    .acc_wr(acc_wr), .acc_rd(acc_rd), .size(acc_size_e'(acc_size)),
    .wdata(acc_wdata), .tx_count(tx_count), .rx_count(rx_count),
    .rx_peek(rx_peek), .tx_push_n(tx_push_n), .tx_bytes(tx_bytes),
    .rx_pop_n(rx_pop_n), .rdata_next(rdata_next)
  );

  cdf_ring #(.DEPTH(DEPTH), .PUSH_N(LANES), .POP_N(1)) u_tx_ring (
    .clk(clk), .rst_n(rst_n), .clear(xfer_start), .flush(tx_flush),
    .push_n(tx_push_n), .push_bytes(tx_bytes), .pop_n(tx_fire),
    .peek(tx_peek), .count(tx_count)
  );

  cdf_ring #(.DEPTH(DEPTH), .PUSH_N(1), .POP_N(LANES)) u_rx_ring (
    .clk(clk), .rst_n(rst_n), .clear(xfer_start), .flush(1'b0),
    .push_n(rx_fire), .push_bytes(rx_push_bytes), .pop_n(rx_pop_n),
    .peek(rx_peek), .count(rx_count)
  );

  cdf_xfer #(.DEPTH(DEPTH), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_xfer (
    .clk(clk), .rst_n(rst_n), .start(xfer_start), .dir_wr_in(xfer_dir_wr),
    .blk_len(blk_len), .blk_cnt(blk_cnt), .clk_en(clk_en),
    .tx_count(tx_count), .rx_count(rx_count), .cd_tx_ready(cd_tx_ready),
    .cd_rx_valid(cd_rx_valid), .acc_rd(acc_rd), .busy(busy),
    .cd_tx_valid(cd_tx_valid), .cd_rx_ready(cd_rx_ready), .tx_fire(tx_fire),
    .rx_fire(rx_fire), .tx_req(tx_req), .rx_req(rx_req),
    .data_done(data_done), .prog_done(prog_done), .rem(rem)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_rdata <= '0;
    else if (acc_rd) acc_rdata <= rdata_next;
  end
endmodule

// File: rtl/cdf_checker.sv
module cdf_checker #(
  parameter int DEPTH = 32,
  parameter int CW    = 28,
  localparam int PW = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clk_en,
  input logic          start,
  input logic          cd_tx_valid,
  input logic          cd_tx_ready,
  input logic [7:0]    cd_tx_data,
  input logic          cd_rx_valid,
  input logic          cd_rx_ready,
  input logic          busy,
  input logic          data_done,
  input logic          prog_done,
  input logic [PW:0]   tx_count,
  input logic [PW:0]   rx_count,
  input logic [CW-1:0] rem
);
  AST_TX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_count <= (PW+1)'(DEPTH)); // R3
  AST_RX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= (PW+1)'(DEPTH)); // R7
  AST_RX_FULL_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == (PW+1)'(DEPTH)) |-> !cd_rx_ready); // R7
  AST_CLKOFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |-> (!cd_tx_valid && !cd_rx_ready)); // R12
  AST_ONE_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
    !(cd_tx_valid && cd_rx_ready)); // R6
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cd_tx_valid && !cd_tx_ready && !start) |=> (!cd_tx_valid || $stable(cd_tx_data))); // R6
  AST_REM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (((cd_tx_valid && cd_tx_ready) || (cd_rx_valid && cd_rx_ready)) && !start)
      |=> (rem == $past(rem) - CW'(1))); // R5
  AST_DONE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_done) |-> !busy); // R8
  AST_PROG_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |-> data_done); // R8
endmodule

bind card_data_fifo cdf_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .start(xfer_start),
  .cd_tx_valid(cd_tx_valid), .cd_tx_ready(cd_tx_ready), .cd_tx_data(cd_tx_data),
  .cd_rx_valid(cd_rx_valid), .cd_rx_ready(cd_rx_ready), .busy(busy),
  .data_done(data_done), .prog_done(prog_done), .tx_count(tx_count),
  .rx_count(rx_count), .rem(rem)
);

// File: tb/card_data_fifo_tb.sv
module card_data_fifo_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_en = 1'b0;
  logic        xfer_start = 1'b0, xfer_dir_wr = 1'b0;
  logic [11:0] blk_len = '0;
  logic [15:0] blk_cnt = '0;
  logic        acc_wr = 1'b0, acc_rd = 1'b0;
  logic [1:0]  acc_size = '0;
  logic [31:0] acc_wdata = '0, acc_rdata;
  logic        tx_flush = 1'b0;
  logic        cd_tx_valid, cd_tx_ready = 1'b0;
  logic [7:0]  cd_tx_data;
  logic        cd_rx_valid = 1'b0, cd_rx_ready;
  logic [7:0]  cd_rx_data, rx_seed = 8'h00;
  logic        busy, tx_req, rx_req, data_done, prog_done;

  int   n_chk = 0, n_fail = 0;
  int   tx_n = 0, rx_n = 0;
  logic [7:0] txq [64];
  bit   finished = 1'b0;

  always #2 clk = ~clk;

  card_data_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .xfer_start(xfer_start),
    .xfer_dir_wr(xfer_dir_wr), .blk_len(blk_len), .blk_cnt(blk_cnt),
    .acc_wr(acc_wr), .acc_rd(acc_rd), .acc_size(acc_size),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .tx_flush(tx_flush),
    .cd_tx_valid(cd_tx_valid), .cd_tx_ready(cd_tx_ready), .cd_tx_data(cd_tx_data),
    .cd_rx_valid(cd_rx_valid), .cd_rx_ready(cd_rx_ready), .cd_rx_data(cd_rx_data),
    .busy(busy), .tx_req(tx_req), .rx_req(rx_req),
    .data_done(data_done), .prog_done(prog_done)
  );

  assign cd_rx_data = rx_seed + rx_n[7:0];

  always @(posedge clk) begin
    if (cd_tx_valid && cd_tx_ready) begin
      txq[tx_n[5:0]] <= cd_tx_data;
      tx_n <= tx_n + 1;
    end
    if (cd_rx_valid && cd_rx_ready) rx_n <= rx_n + 1;
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_xfer(input logic dir, input logic [11:0] len, input logic [15:0] cnt);
    @(negedge clk);
    xfer_dir_wr = dir; blk_len = len; blk_cnt = cnt; xfer_start = 1'b1;
    @(negedge clk);
    xfer_start = 1'b0;
  endtask

  task automatic wr(input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    acc_size = sz; acc_wdata = d; acc_wr = 1'b1;
    @(negedge clk);
    acc_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sz, output logic [31:0] d);
    @(negedge clk);
    acc_size = sz; acc_rd = 1'b1;
    @(negedge clk);
    acc_rd = 1'b0;
    d = acc_rdata;
  endtask

  task automatic t_reset;
    chk(busy, 0, "R1 busy");
    chk(cd_tx_valid, 0, "R1 tx_valid");
    chk(cd_rx_ready, 0, "R1 rx_ready");
    chk({tx_req, rx_req}, 0, "R1 requests");
    chk({data_done, prog_done}, 0, "R1 done flags");
  endtask

  task automatic t_pack;
    int n0;
    logic [7:0] exp [7] = '{8'hA1, 8'hB2, 8'hC3, 8'hD4, 8'hE5, 8'hF6, 8'h77};
    clk_en = 1'b0; cd_tx_ready = 1'b0;
    start_xfer(1'b1, 12'd7, 16'd1);
    chk(tx_req, 1, "R9 tx_req while bytes remain");
    wr(2'd2, 32'hA1B2C3D4);
    wr(2'd1, 32'h1234E5F6);
    wr(2'd0, 32'hFFFFFF77);
    cyc(1);
    chk(cd_tx_valid, 0, "R12 no transfer with clk_en low");
    n0 = tx_n;
    clk_en = 1'b1;
    cyc(1);
    chk(cd_tx_valid, 1, "R6 valid under back-pressure");
    chk(cd_tx_data, 8'hA1, "R6 head byte");
    cyc(2);
    chk(cd_tx_data, 8'hA1, "R6 data held while stalled");
    chk(tx_n - n0, 0, "R6 nothing taken while stalled");
    cd_tx_ready = 1'b1;
    cyc(10);
    chk(tx_n - n0, 7, "R5 byte count len*cnt");
    for (int i = 0; i < 7; i++) chk(txq[(n0 + i) % 64], exp[i], "R2 MSB-lane-first order");
    chk({busy, data_done, prog_done}, 3'b011, "R8 write completion flags");
    chk(tx_req, 0, "R9 tx_req drops at completion");
  endtask

  task automatic t_overflow;
    int n0;
    clk_en = 1'b0; cd_tx_ready = 1'b1;
    start_xfer(1'b1, 12'd40, 16'd1);
    for (int i = 0; i < 9; i++)
      wr(2'd2, {8'(4*i), 8'(4*i+1), 8'(4*i+2), 8'(4*i+3)});
    n0 = tx_n;
    clk_en = 1'b1;
    cyc(40);
    chk(tx_n - n0, 32, "R3 only 32 bytes buffered");
    for (int i = 0; i < 32; i++) chk(txq[(n0 + i) % 64], 8'(i), "R3 kept bytes in order");
    chk(data_done, 0, "R8 not done while bytes remain");
    wr(2'd2, 32'h20212223);
    wr(2'd3, 32'h24252627);
    cyc(12);
    chk(tx_n - n0, 40, "R5 full count sent");
    chk(txq[(n0 + 32) % 64], 8'h20, "R3 refill after drain");
    chk(txq[(n0 + 39) % 64], 8'h27, "R2 size code 3 is 4 bytes");
    chk(data_done, 1, "R8 done after 40 bytes");
  endtask

  task automatic t_read;
    int n0;
    logic [7:0] f;
    logic [31:0] d;
    clk_en = 1'b1; rx_seed = 8'h40; cd_rx_valid = 1'b1;
    n0 = rx_n;
    f = rx_seed + n0[7:0];
    start_xfer(1'b0, 12'd3, 16'd2);
    cyc(10);
    chk(rx_n - n0, 6, "R5 read byte count len*cnt");
    chk(rx_req, 1, "R10 rx_req set by received bytes");
    chk({busy, data_done, prog_done}, 3'b010, "R8 read completion, no prog_done");
    rd(2'd2, d);
    chk(d, {f, f + 8'd1, f + 8'd2, f + 8'd3}, "R4 word unpack MSB first");
    chk(rx_req, 0, "R10 rx_req cleared by read");
    rd(2'd2, d);
    chk(d, {f + 8'd4, f + 8'd5, 16'h0000}, "R4 missing lanes zero");
    rd(2'd0, d);
    chk(d, 0, "R4 empty read is zero");
  endtask

  task automatic t_full;
    int n0;
    logic [7:0] f;
    logic [31:0] d;
    clk_en = 1'b1; cd_rx_valid = 1'b1;
    n0 = rx_n;
    f = rx_seed + n0[7:0];
    start_xfer(1'b0, 12'd40, 16'd1);
    cyc(45);
    chk(rx_n - n0, 32, "R7 stops at 32 bytes");
    chk(cd_rx_ready, 0, "R7 ready low when full");
    chk(data_done, 0, "R8 not done while bytes remain");
    rd(2'd1, d);
    chk(d, {16'h0000, f, f + 8'd1}, "R4 half unpack");
    cyc(4);
    chk(rx_n - n0, 34, "R7 resumes after space frees");
    cd_rx_valid = 1'b0;
  endtask

  task automatic t_flush;
    int n0;
    clk_en = 1'b0; cd_tx_ready = 1'b1;
    start_xfer(1'b1, 12'd4, 16'd1);
    wr(2'd2, 32'hDEADBEEF);
    @(negedge clk); tx_flush = 1'b1;
    @(negedge clk); tx_flush = 1'b0;
    n0 = tx_n;
    clk_en = 1'b1;
    cyc(3);
    chk(tx_n - n0, 0, "R11 flushed bytes not sent");
    wr(2'd2, 32'h01020304);
    cyc(8);
    chk(tx_n - n0, 4, "R11 new bytes sent");
    chk({txq[n0 % 64], txq[(n0 + 3) % 64]}, 16'h0104, "R11 new data follows flush");
    chk(data_done, 1, "R8 done after flush test");
  endtask

  task automatic t_zero;
    int n0;
    clk_en = 1'b1;
    n0 = tx_n;
    start_xfer(1'b1, 12'd100, 16'd0);
    cyc(3);
    chk({busy, data_done}, 2'b01, "R8 zero length completes");
    chk(tx_n - n0, 0, "R8 zero length moves no byte");
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_pack();
    t_overflow();
    t_read();
    t_full();
    t_flush();
    t_zero();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule